// File: doc/BRIEF.md
# Cache-Line Message Packetizer

This block turns protocol messages into flits for an on-chip network link whose physical digit is the same width as a flit. A message arrives on a valid/ready interface. Each message carries a route field, a virtual-channel number, an address, a command code, a class bit and a 64-byte line. The block registers the message and then emits its flits on a valid/ready output. A 2-bit kind tag beside each flit says where that flit sits in its packet.

There are two message classes. A coherence command needs no payload, so it leaves as a single flit that is both head and tail. A data message carries a cache line, so it becomes a five-flit packet: a header flit, then the line cut into 16-byte slices. The slices go out lowest bytes first, and the last slice is marked as tail.

The block holds only one message. It accepts the next message during the cycle in which the final flit of the current one is taken, so consecutive packets leave with no idle cycle between them.

Top module: `msg_packetizer`

## Requirements
- R1: During and after a synchronous active-high reset, `out_valid` is 0 and `in_ready` is 1 until a message is accepted.
- R2: `out_kind` encodes the flit position as 2'b00 head, 2'b01 body, 2'b10 tail and 2'b11 head-and-tail.
- R3: A message with `in_is_line`=0 produces exactly one flit, of kind 2'b11.
- R4: A message with `in_is_line`=1 produces exactly five flits: one head (2'b00), three body (2'b01) and one tail (2'b10), in that order.
- R5: Head and head-and-tail flits carry the header in `out_data`: route in bits [7:0], virtual channel in [9:8], address in [49:10] and command in [57:50]. Bits [127:58] are zero.
- R6: The k-th payload flit of a line packet (k = 1..4) carries `in_line[128k-1 : 128(k-1)]`. This is bytes 16(k-1) to 16k-1 in ascending order, with byte 0 in bits [7:0] of the first payload flit.
- R7: `in_ready` is 1 only while no flit is pending, or while the last flit of the current message (kind 2'b10 or 2'b11) is being accepted (`out_ready`=1).
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_kind` and `out_data` keep their values into the next cycle.
- R9: A message accepted in the same cycle as the last flit of the previous message appears on the output in the next cycle, with no idle cycle between them.
- R10: After a message is accepted, changes on the message inputs do not alter any flit of that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message offered |
| in_ready | output | 1 | Message can be taken this cycle |
| in_is_line | input | 1 | 1 = data message with cache line, 0 = coherence command |
| in_route | input | 8 | Route information for the header |
| in_vc | input | 2 | Virtual channel number |
| in_addr | input | 40 | Address |
| in_cmd | input | 8 | Command code |
| in_line | input | 512 | 64-byte cache line, byte 0 in bits [7:0] |
| out_valid | output | 1 | Flit offered |
| out_ready | input | 1 | Downstream takes the flit |
| out_kind | output | 2 | Flit position tag |
| out_data | output | 128 | Flit contents |

## Verification
The properties assume the downstream side follows the valid/ready rule: a flit counts as transferred only in a cycle where both signals are high, and `out_ready` may change freely between cycles. They also assume the upstream side holds a message stable from when it raises `in_valid` until the handshake. The stimulus changes message fields only after acceptance and keeps `in_valid` low between messages. It drives `out_ready` high continuously in one phase to test back-to-back timing, and from a pseudo-random sequence in the other phase so that stalls land on every flit position.

// File: rtl/msg_pkt_pkg.sv
package msg_pkt_pkg;

    localparam int ROUTE_W     = 8;
    localparam int VC_W        = 2;
    localparam int ADDR_W      = 40;
    localparam int CMD_W       = 8;
    localparam int CHUNK_BYTES = 16;
    localparam int LINE_BYTES  = 64;

    localparam int FLIT_W  = CHUNK_BYTES * 8;
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int N_CHUNK = LINE_BYTES / CHUNK_BYTES;
    localparam int N_BEAT  = N_CHUNK + 1;
    localparam int BEAT_W  = $clog2(N_BEAT);
    localparam int IDX_W   = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1;
    localparam int HDR_W   = ROUTE_W + VC_W + ADDR_W + CMD_W;

    typedef enum logic [1:0] {
        FK_HEAD = 2'b00,
        FK_BODY = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    // route sits in the least significant bits of the packed header
    typedef struct packed {
        logic [CMD_W-1:0]   cmd;
        logic [ADDR_W-1:0]  addr;
        logic [VC_W-1:0]    vc;
        logic [ROUTE_W-1:0] route;
    } msg_hdr_t;

    typedef struct packed {
        logic              is_line;
        msg_hdr_t          hdr;
        logic [LINE_W-1:0] line;
    } msg_t;

    function automatic flit_kind_e kind_for(input logic is_line,
                                            input logic [BEAT_W-1:0] beat);
        if (!is_line)
            return FK_SOLO;
        else if (beat == '0)
            return FK_HEAD;
        else if (beat == BEAT_W'(N_BEAT - 1))
            return FK_TAIL;
        else
            return FK_BODY;
    endfunction

endpackage

// File: rtl/pkt_header_build.sv
module pkt_header_build
    import msg_pkt_pkg::*;
#(
    parameter int OUT_W = FLIT_W
) (
    input  msg_hdr_t         hdr,
    output logic [OUT_W-1:0] flit
);
    always_comb begin
        flit = '0;
        flit[HDR_W-1:0] = hdr;
    end
endmodule

// File: rtl/pkt_line_slicer.sv
module pkt_line_slicer
    import msg_pkt_pkg::*;
#(
    parameter int SLICES  = N_CHUNK,
    parameter int SLICE_W = FLIT_W,
    parameter int SEL_W   = IDX_W
) (
    input  logic [SLICES*SLICE_W-1:0] line,
    input  logic [SEL_W-1:0]          sel,
    output logic [SLICE_W-1:0]        slice
);
    logic [SLICE_W-1:0] parts [SLICES];

    for (genvar i = 0; i < SLICES; i++) begin : g_part
        assign parts[i] = line[i*SLICE_W +: SLICE_W];
    end

    assign slice = parts[sel];
endmodule

// File: rtl/pkt_beat_seq.sv
module pkt_beat_seq
    import msg_pkt_pkg::*;
#(
    parameter int BEATS = N_BEAT,
    parameter int CNT_W = BEAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_is_line,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             load,
    output logic             valid,
    output logic             is_line,
    output logic [CNT_W-1:0] beat
);
    logic last;
    logic fire;

    assign last     = valid && (is_line ? (beat == CNT_W'(BEATS - 1)) : (beat == '0));
    assign fire     = valid && out_ready;
    assign in_ready = !valid || (out_ready && last);
    assign load     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            is_line <= 1'b0;
            beat    <= '0;
        end else if (load) begin
            valid   <= 1'b1;
            is_line <= in_is_line;
            beat    <= '0;
        end else if (fire) begin
            if (last)
                valid <= 1'b0;
            else
                beat <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/msg_packetizer.sv
module msg_packetizer
    import msg_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_is_line,
    input  logic [ROUTE_W-1:0] in_route,
    input  logic [VC_W-1:0]   in_vc,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [LINE_W-1:0] in_line,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [FLIT_W-1:0] out_data
);
    msg_t              msg_q;
    logic              load;
    logic              seq_is_line;
    logic [BEAT_W-1:0] beat;
    logic [FLIT_W-1:0] hdr_flit;
    logic [FLIT_W-1:0] pay_flit;
    logic [IDX_W-1:0]  slice_sel;
    flit_kind_e        kind;

    pkt_beat_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_is_line(in_is_line),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .load      (load),
        .valid     (out_valid),
        .is_line   (seq_is_line),
        .beat      (beat)
    );

    // message register: captured once per accepted message
    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
        end else if (load) begin
            msg_q.is_line   <= in_is_line;
            msg_q.hdr.route <= in_route;
            msg_q.hdr.vc    <= in_vc;
            msg_q.hdr.addr  <= in_addr;
            msg_q.hdr.cmd   <= in_cmd;
            msg_q.line      <= in_line;
        end
    end

    pkt_header_build u_hdr (
        .hdr (msg_q.hdr),
        .flit(hdr_flit)
    );

    assign slice_sel = IDX_W'(beat - 1'b1);

    pkt_line_slicer u_slice (
        .line (msg_q.line),
        .sel  (slice_sel),
        .slice(pay_flit)
    );

    assign kind     = kind_for(seq_is_line, beat);
    assign out_kind = kind;
    assign out_data = (beat == '0) ? hdr_flit : pay_flit;
endmodule

// File: rtl/msg_packetizer_chk.sv
module msg_packetizer_chk
    import msg_pkt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_kind,
    input logic [FLIT_W-1:0] out_data
);
    logic       hs;
    logic [2:0] body_seen;

    assign hs = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst)
            body_seen <= '0;
        else if (hs && out_kind == FK_HEAD)
            body_seen <= '0;
        else if (hs && out_kind == FK_BODY)
            body_seen <= body_seen + 1'b1;
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_data)));

    assert_ready_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (in_ready && out_valid) |-> (out_ready && out_kind[1]));

    assert_head_then_body_R4: assert property (@(posedge clk) disable iff (rst)
        (hs && out_kind == FK_HEAD) |=> (out_valid && out_kind == FK_BODY));

    assert_body_count_R4: assert property (@(posedge clk) disable iff (rst)
        (hs && out_kind == FK_TAIL) |-> (body_seen == 3'(N_CHUNK - 1)));

    assert_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
        (hs && out_kind[1] && in_valid && in_ready)
            |=> (out_valid && (out_kind == FK_HEAD || out_kind == FK_SOLO)));

    assert_start_kind_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_kind == FK_HEAD || out_kind == FK_SOLO));

    assert_header_pad_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_kind == FK_HEAD || out_kind == FK_SOLO))
            |-> (out_data[FLIT_W-1:HDR_W] == '0));
endmodule

bind msg_packetizer msg_packetizer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_kind (out_kind),
    .out_data (out_data)
);

// File: tb/tb_msg_packetizer.sv
module tb_msg_packetizer;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic         in_is_line;
    logic [7:0]   in_route;
    logic [1:0]   in_vc;
    logic [39:0]  in_addr;
    logic [7:0]   in_cmd;
    logic [511:0] in_line;
    logic         out_valid;
    logic         out_ready;
    logic [1:0]   out_kind;
    logic [127:0] out_data;

    always #10 clk = ~clk;

    msg_packetizer dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_is_line(in_is_line),
        .in_route(in_route), .in_vc(in_vc), .in_addr(in_addr), .in_cmd(in_cmd),
        .in_line(in_line),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_data(out_data)
    );

    logic [129:0] exp_q [$];
    int           hs_cyc [$];
    int           n_chk = 0;
    int           n_bad = 0;
    int           cyc = 0;
    int           ready_mode = 0;
    logic [15:0]  lfsr = 16'hACE1;
    bit           held = 0;
    logic [129:0] held_val;
    bit           done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= (ready_mode == 0) ? 1'b1 : lfsr[0];
    end

    task automatic check(input bit ok, input string req,
                         input logic [129:0] act, input logic [129:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] mk_line(input int s);
        logic [511:0] l;
        for (int i = 0; i < 64; i++) l[i*8 +: 8] = 8'(s * 7 + i * 13 + 1);
        return l;
    endfunction

    // monitor: samples a quarter period after the falling edge
    always begin
        @(negedge clk);
        #5;
        if (!rst) begin
            if (held) begin
                check(out_valid && {out_kind, out_data} == held_val, "R8 hold",
                      {out_kind, out_data}, held_val);
                held = 0;
            end
            if (out_valid && !out_ready) begin
                held     = 1;
                held_val = {out_kind, out_data};
            end
            if (in_ready && out_valid)
                check(out_ready && out_kind[1], "R7 ready gate",
                      130'({out_ready, out_kind}), 130'({1'b1, 2'b1x}));
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4 R3 extra flit", {out_kind, out_data}, '0);
                end else begin
                    logic [129:0] e;
                    string tag;
                    e = exp_q.pop_front();
                    case (e[129:128])
                        2'b11:   tag = "R2 R3 R5 R10 solo";
                        2'b00:   tag = "R2 R4 R5 R10 head";
                        2'b01:   tag = "R2 R4 R6 R10 body";
                        default: tag = "R2 R4 R6 R10 tail";
                    endcase
                    check({out_kind, out_data} == e, tag, {out_kind, out_data}, e);
                    hs_cyc.push_back(cyc);
                end
            end
        end
    end

    // driver: queues the expected flits, then offers the message
    task automatic send(input bit is_line, input logic [7:0] route, input logic [1:0] vc,
                        input logic [39:0] addr, input logic [7:0] cmd,
                        input logic [511:0] line);
        logic [127:0] hdr;
        hdr = {70'b0, cmd, addr, vc, route};
        if (!is_line) begin
            exp_q.push_back({2'b11, hdr});
        end else begin
            exp_q.push_back({2'b00, hdr});
            for (int k = 0; k < 4; k++)
                exp_q.push_back({(k == 3) ? 2'b10 : 2'b01, line[k*128 +: 128]});
        end
        @(negedge clk);
        in_valid   = 1'b1;
        in_is_line = is_line;
        in_route   = route;
        in_vc      = vc;
        in_addr    = addr;
        in_cmd     = cmd;
        in_line    = line;
        #5;
        while (!in_ready) begin
            @(negedge clk);
            #5;
        end
        @(posedge clk);
        #1;
        // R10: scramble the message fields once the message is taken
        in_valid   = 1'b0;
        in_is_line = ~is_line;
        in_route   = ~route;
        in_vc      = ~vc;
        in_addr    = ~addr;
        in_cmd     = ~cmd;
        in_line    = ~line;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int first;
        rst        = 1'b1;
        in_valid   = 1'b0;
        in_is_line = 1'b0;
        in_route   = '0;
        in_vc      = '0;
        in_addr    = '0;
        in_cmd     = '0;
        in_line    = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #5;
        check(!out_valid && in_ready, "R1 in reset",
              130'({out_valid, in_ready}), 130'(2'b01));
        rst = 1'b0;
        repeat (2) @(negedge clk);
        #5;
        check(!out_valid && in_ready, "R1 after reset",
              130'({out_valid, in_ready}), 130'(2'b01));

        // phase 1: output always ready, back-to-back messages (R9)
        ready_mode = 0;
        first = hs_cyc.size();
        send(1'b0, 8'h5A, 2'd1, 40'h12_3456_789A, 8'hC3, mk_line(1));
        send(1'b1, 8'hA5, 2'd2, 40'hFE_DCBA_9876, 8'h3C, mk_line(2));
        send(1'b0, 8'h0F, 2'd3, 40'h00_0000_0001, 8'h81, mk_line(3));
        drain();
        check(hs_cyc.size() - first == 7, "R4 R3 flit total",
              130'(hs_cyc.size() - first), 130'(7));
        if (hs_cyc.size() - first == 7)
            check(hs_cyc[first + 6] - hs_cyc[first] == 6, "R9 no gap",
                  130'(hs_cyc[first + 6] - hs_cyc[first]), 130'(6));

        // phase 2: pseudo-random stalls on the output
        ready_mode = 1;
        for (int m = 0; m < 24; m++) begin
            send(((m % 3) != 1), 8'(m * 29 + 3), 2'(m), 40'(64'h1_0000_0041 * (m + 5)),
                 8'(m * 17 + 9), mk_line(m + 10));
        end
        drain();
        check(exp_q.size() == 0, "R4 all flits seen", 130'(exp_q.size()), 130'(0));

        done = 1;
        finish_run();
    end
endmodule